// File: doc/BRIEF.md
# Prioritized UART interrupt identifier

This block is the interrupt-control slice of a 16550-style serial port. It holds the interrupt enable register, latches the transmit-holding-empty event, and combines five source conditions with the enable bits. The highest-priority enabled source is shown as a 3-bit identification code with an active-low pending flag. A registered, active-high level interrupt request follows the pending state.

The conditions for line-status error, received data at the trigger level, character timeout and modem-status change arrive as levels from neighbouring logic. Transmit-holding-empty arrives as a one-cycle event and is held inside the block. It is released when software reads the identification register while that code is shown, or when the holding register is written. The identification register is combinational from the held state and the live inputs. Software can therefore read it in the same cycle as its read strobe.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register resets to 0x00. A write stores data bits 3:0 (bit 0 received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status), visible on the next cycle. Bits 7:4 always read 0.
- R2: After reset the identification byte reads 0x01 and the interrupt output is low.
- R3: An enabled line-status condition shows code 011 in bits 3:1, whatever else is pending.
- R4: Received data shows code 010 and character timeout shows code 110. Both are gated by enable bit 0. Received data wins when both are pending, and both win over transmit empty and modem status.
- R5: Transmit empty shows code 001 and wins over modem status. Modem status shows code 000.
- R6: Bit 0 of the identification byte reads 0 while any enabled source is pending and 1 otherwise. With nothing pending, bits 3:1 read 000.
- R7: Bits 7:6 read 11 while the FIFO-enable input is high and 00 otherwise. Bits 5:4 always read 00.
- R8: A transmit-empty event is held from the next cycle onward. It is cleared on the cycle after an identification read that shows code 001, or after a holding-register write. A read showing another code leaves it held.
- R9: A source whose enable bit is clear never appears in the code and never raises the interrupt output.
- R10: The interrupt output in each cycle equals the pending state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | DATA_W | Enable register write data |
| ier_rdata | output | DATA_W | Enable register read value |
| src_line_err | input | 1 | Receiver line-status condition |
| src_rx_avail | input | 1 | Received data at trigger level |
| src_rx_tmo | input | 1 | Character timeout condition |
| tx_empty_evt | input | 1 | Transmit holding register became empty (pulse) |
| tx_hold_wr | input | 1 | Transmit holding register write (pulse) |
| src_modem | input | 1 | Modem-status change condition |
| fifo_on | input | 1 | FIFOs enabled |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | DATA_W | Identification register value |
| irq | output | 1 | Registered level interrupt, active high |

## Verification
The identification byte responds in the same cycle to the level sources and to the FIFO-enable input. It responds one cycle late to enable writes, to transmit-empty events, and to the clearing actions for that event. The interrupt output lags the pending flag by exactly one cycle. The driver applies each stimulus just after a rising edge, and a reference model advances its held state at that same edge. The expectation is then queued, and the monitor compares it at the following falling edge. Every delayed effect is therefore checked in the first cycle in which it must be visible.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int EN_BITS = 4;
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;
    localparam int ID_W    = 3;
    localparam int NSRC    = 5;

    typedef enum logic [ID_W-1:0] {
        ID_LINE  = 3'b011,
        ID_RXAV  = 3'b010,
        ID_RXTMO = 3'b110,
        ID_TXE   = 3'b001,
        ID_MODEM = 3'b000
    } irq_id_e;

    // index 0 is highest priority
    localparam logic [ID_W-1:0] PRIO_CODE [NSRC] = '{ID_LINE, ID_RXAV, ID_RXTMO, ID_TXE, ID_MODEM};

    typedef struct packed {
        logic [EN_BITS-1:0] en;
    } en_state_t;

    typedef struct packed {
        logic held;
    } txe_state_t;

    typedef struct packed {
        logic irq;
    } out_state_t;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [EN_BITS-1:0] en,
    output logic [DATA_W-1:0] rdata
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.en = wdata[EN_BITS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

    always_comb begin
        rdata = '0;
        rdata[EN_BITS-1:0] = st_q.en;
    end
endmodule

// File: rtl/irq_txe_latch.sv
module irq_txe_latch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic hold_wr,
    input  logic ack_rd,
    output logic held
);
    txe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt)               st_d.held = 1'b1;
        else if (hold_wr || ack_rd) st_d.held = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.held;
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output logic [ID_W-1:0] code,
    output logic            valid
);
    always_comb begin
        code  = '0;
        valid = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                code  = PRIO_CODE[i];
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_wdata,
    output logic [DATA_W-1:0] ier_rdata,
    input  logic              src_line_err,
    input  logic              src_rx_avail,
    input  logic              src_rx_tmo,
    input  logic              tx_empty_evt,
    input  logic              tx_hold_wr,
    input  logic              src_modem,
    input  logic              fifo_on,
    input  logic              iir_rd,
    output logic [DATA_W-1:0] iir_rdata,
    output logic              irq
);
    logic [EN_BITS-1:0] en;
    logic               txe_held;
    logic [NSRC-1:0]    req;
    logic [ID_W-1:0]    code;
    logic               pend;
    logic               txe_ack;
    out_state_t         st_d, st_q;

    irq_enable_reg #(.DATA_W(DATA_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
        .en(en), .rdata(ier_rdata)
    );

    assign txe_ack = iir_rd && pend && (code == ID_TXE);

    irq_txe_latch u_txe (
        .clk(clk), .rst_n(rst_n), .set_evt(tx_empty_evt),
        .hold_wr(tx_hold_wr), .ack_rd(txe_ack), .held(txe_held)
    );

    // request vector in priority order, index 0 highest
    assign req = {src_modem    & en[EN_MS],
                  txe_held     & en[EN_TX],
                  src_rx_tmo   & en[EN_RX],
                  src_rx_avail & en[EN_RX],
                  src_line_err & en[EN_LS]};

    irq_prio_encoder u_enc (.req(req), .code(code), .valid(pend));

    always_comb begin
        iir_rdata = '0;
        iir_rdata[7:6] = {2{fifo_on}};
        iir_rdata[ID_W:1] = code;
        iir_rdata[0] = ~pend;
    end

    always_comb begin
        st_d = st_q;
        st_d.irq = pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ier_rdata,
    input logic              src_line_err,
    input logic              tx_empty_evt,
    input logic              fifo_on,
    input logic              iir_rd,
    input logic [DATA_W-1:0] iir_rdata,
    input logic              irq
);
    // R1
    ier_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[7:4] == 4'b0000);

    // R3
    line_top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_line_err && ier_rdata[2]) |-> iir_rdata[3:1] == 3'b011);

    // R6
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[0] |-> iir_rdata[3:1] == 3'b000);

    // R7
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[7:4] == {{2{fifo_on}}, 2'b00});

    // R8
    txe_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !iir_rdata[0] && iir_rdata[3:1] == 3'b001 && !tx_empty_evt)
        |=> iir_rdata[3:1] != 3'b001);

    // R9
    line_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rdata[2] |-> iir_rdata[3:1] != 3'b011);

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == !$past(iir_rdata[0]));
endmodule

bind uart_irq_ident irq_ident_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ier_rdata(ier_rdata), .src_line_err(src_line_err),
    .tx_empty_evt(tx_empty_evt), .fifo_on(fifo_on), .iir_rd(iir_rd),
    .iir_rdata(iir_rdata), .irq(irq)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata, iir_rdata;
    logic src_line_err = 0, src_rx_avail = 0, src_rx_tmo = 0;
    logic tx_empty_evt = 0, tx_hold_wr = 0, src_modem = 0;
    logic fifo_on = 0, iir_rd = 0;
    logic irq;

    always #4 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .src_line_err(src_line_err), .src_rx_avail(src_rx_avail),
        .src_rx_tmo(src_rx_tmo), .tx_empty_evt(tx_empty_evt), .tx_hold_wr(tx_hold_wr),
        .src_modem(src_modem), .fifo_on(fifo_on), .iir_rd(iir_rd),
        .iir_rdata(iir_rdata), .irq(irq)
    );

    typedef struct packed {
        logic wr; logic [7:0] wd;
        logic ls; logic ra; logic to; logic te; logic tw; logic ms; logic ff; logic rd;
    } stim_t;

    typedef struct {
        string rq; logic [7:0] iir; logic irq; logic [7:0] ier;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [3:0] m_ier = '0;
    logic m_txe = 0;
    logic m_irq = 0;
    stim_t prev = '0;

    // returns {pending, code}
    function automatic logic [3:0] model_id(logic [3:0] en, logic txe, stim_t s);
        if (s.ls && en[2])      return 4'b1011;
        else if (s.ra && en[0]) return 4'b1010;
        else if (s.to && en[0]) return 4'b1110;
        else if (txe && en[1])  return 4'b1001;
        else if (s.ms && en[3]) return 4'b1000;
        else                    return 4'b0000;
    endfunction

    task automatic step(string rq, stim_t s);
        logic [3:0] pc;
        exp_t e;
        @(posedge clk);
        #1;
        pc = model_id(m_ier, m_txe, prev);
        m_irq = pc[3];
        if (prev.te) m_txe = 1'b1;
        else if (prev.tw || (prev.rd && pc == 4'b1001)) m_txe = 1'b0;
        if (prev.wr) m_ier = prev.wd[3:0];
        ier_wr = s.wr; ier_wdata = s.wd; src_line_err = s.ls; src_rx_avail = s.ra;
        src_rx_tmo = s.to; tx_empty_evt = s.te; tx_hold_wr = s.tw; src_modem = s.ms;
        fifo_on = s.ff; iir_rd = s.rd;
        prev = s;
        pc = model_id(m_ier, m_txe, s);
        e.rq = rq;
        e.iir = {{2{s.ff}}, 2'b00, pc[2:0], ~pc[3]};
        e.irq = m_irq;
        e.ier = {4'b0000, m_ier};
        q.push_back(e);
    endtask

    function automatic stim_t mk(logic wr, logic [7:0] wd, logic ls, logic ra, logic to,
                                 logic te, logic tw, logic ms, logic ff, logic rd);
        stim_t s;
        s.wr = wr; s.wd = wd; s.ls = ls; s.ra = ra; s.to = to;
        s.te = te; s.tw = tw; s.ms = ms; s.ff = ff; s.rd = rd;
        return s;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks += 3;
            if (iir_rdata !== e.iir) begin
                fails++;
                $display("FAIL %s iir got %h exp %h", e.rq, iir_rdata, e.iir);
            end
            if (irq !== e.irq) begin
                fails++;
                $display("FAIL R10 (%s) irq got %b exp %b", e.rq, irq, e.irq);
            end
            if (ier_rdata !== e.ier) begin
                fails++;
                $display("FAIL R1 (%s) ier got %h exp %h", e.rq, ier_rdata, e.ier);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R2", mk(0,8'h00,0,0,0,0,0,0,0,0));
        step("R1", mk(1,8'hFF,0,0,0,0,0,0,0,0));
        step("R1", mk(0,8'h00,0,0,0,0,0,0,0,0));
        step("R3", mk(0,8'h00,1,1,1,0,0,1,0,0));
        step("R4", mk(0,8'h00,0,1,1,0,0,1,0,0));
        step("R4", mk(0,8'h00,0,0,1,0,0,1,0,0));
        step("R5", mk(0,8'h00,0,0,0,1,0,1,0,0));
        step("R5", mk(0,8'h00,0,0,0,0,0,1,0,0));
        step("R8", mk(0,8'h00,1,0,0,0,0,0,0,1));
        step("R8", mk(0,8'h00,0,0,0,0,0,1,0,1));
        step("R5", mk(0,8'h00,0,0,0,0,0,1,0,0));
        step("R6", mk(0,8'h00,0,0,0,0,0,0,0,0));
        step("R8", mk(0,8'h00,0,0,0,1,0,0,0,0));
        step("R8", mk(0,8'h00,0,0,0,0,1,0,0,0));
        step("R8", mk(0,8'h00,0,0,0,0,0,0,0,0));
        step("R7", mk(0,8'h00,0,1,0,0,0,0,1,0));
        step("R7", mk(0,8'h00,0,0,0,0,0,0,1,0));
        step("R9", mk(1,8'h00,1,1,1,1,0,1,0,0));
        step("R9", mk(0,8'h00,1,1,1,0,0,1,0,0));
        step("R9", mk(0,8'h00,0,0,0,0,0,0,0,0));
        step("R6", mk(0,8'h00,0,0,0,0,0,0,0,0));
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule